// File: doc/BRIEF.md
# Sleep-Mode Entry/Exit Controller

This block governs the low-power rest state of a synchronous memory. A sleep request arrives from outside the clock domain. The block resynchronises it and walks a small state machine through entry, rest, exit and a post-wake guard window. Entry and exit each take a fixed two clocks once the request has been resynchronised. From the first entry clock until the guard window closes, the block suppresses every array write and every output drive coming from the memory core. Any access that was in flight is therefore dropped, and the data pins stay released when the memory wakes.

The memory expects the surrounding system to be idle around a rest period. The block checks that at two points. A request that lands while the chip is selected still puts the memory to sleep, but it sets a violation flag. So does any select or address strobe seen during the wake-up guard window. The flag holds until reset. Power switching and retention cells are outside this block. It only provides the timing and the gating that make them safe.

Top module: `slp_mode_ctrl`

## Requirements
- R1: After a synchronous reset, sleep_active, access_inhibit, recov_busy and violation are all 0.
- R2: The raw request passes two synchroniser flops. When it rises before clock edge k, access_inhibit rises after edge k+2 and sleep_active rises after edge k+3.
- R3: When the request falls before edge m, sleep_active stays 1 through edge m+2 and falls after edge m+3. recov_busy is 1 from edge m+3 for RECOV_CYC cycles (default 2) and is 0 again after edge m+5.
- R4: While access_inhibit is 1, arr_wr_en and dq_drive_en are 0 whatever core_wr and core_oe do. access_inhibit covers entry, rest, exit and the guard window.
- R5: While access_inhibit is 0, arr_wr_en equals core_wr and dq_drive_en equals core_oe.
- R6: A synchronised request seen for only one clock aborts the entry. access_inhibit is 1 for a single cycle and sleep_active never rises.
- R7: chip_sel, strb_proc or strb_ctrl high at an edge while recov_busy is 1 sets violation after that edge.
- R8: chip_sel high at the edge where entry starts sets violation after that edge, and sleep_active still rises one edge later.
- R9: Once set, violation stays 1 until reset.
- R10: Selects and strobes after the guard window has closed, and outside any request, leave violation at 0.
- R11: A request that drops for only one synchronised clock during rest returns the block to rest. sleep_active stays 1 and recov_busy never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sleep_req_async | input | 1 | Asynchronous sleep request, active high |
| chip_sel | input | 1 | Decoded chip select, active high |
| strb_proc | input | 1 | Processor-side address strobe, active high |
| strb_ctrl | input | 1 | Controller-side address strobe, active high |
| core_wr | input | 1 | Write request from the memory core |
| core_oe | input | 1 | Output-drive request from the memory core |
| sleep_active | output | 1 | Memory is in the rest state (rest and exit phases) |
| access_inhibit | output | 1 | All accesses blocked (entry through guard window) |
| recov_busy | output | 1 | Wake-up guard window is open |
| violation | output | 1 | Sticky protocol-violation flag |
| arr_wr_en | output | 1 | Gated write enable to the array |
| dq_drive_en | output | 1 | Gated data-output drive enable |

## Verification
Entry start and the select check fall on the same clock edge. The bench raises the request and chip_sel at the same time and holds both. It then expects violation and access_inhibit to rise after the same edge, and sleep_active to follow one edge later. That shows the violation did not stop the entry. The guard-window check also shares edges with the exit sequence. A strobe placed exactly one edge after recov_busy rises must set the flag. A select placed after the window has closed must leave it clear.

// File: rtl/slp_pkg.sv
package slp_pkg;
  typedef enum logic [2:0] {
    ST_AWAKE  = 3'd0,
    ST_ENTER  = 3'd1,
    ST_ASLEEP = 3'd2,
    ST_EXIT   = 3'd3,
    ST_RECOV  = 3'd4
  } slp_state_e;
endpackage

// File: rtl/slp_sync.sv
module slp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/slp_fsm.sv
module slp_fsm
  import slp_pkg::*;
#(
  parameter int ENTRY_CYC = 2,
  parameter int EXIT_CYC  = 2,
  parameter int RECOV_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_s,
  output logic enter_evt,
  output logic sleep_q,
  output logic inhib_q,
  output logic recov_q
);
  localparam int MAXC1 = (ENTRY_CYC > EXIT_CYC) ? ENTRY_CYC : EXIT_CYC;
  localparam int MAXC  = (MAXC1 > RECOV_CYC) ? MAXC1 : RECOV_CYC;
  localparam int CW    = (MAXC < 2) ? 1 : $clog2(MAXC + 1);
  localparam logic [CW-1:0] ENT_LAST = CW'(ENTRY_CYC - 2);
  localparam logic [CW-1:0] EXT_LAST = CW'(EXIT_CYC - 2);
  localparam logic [CW-1:0] REC_LAST = CW'(RECOV_CYC - 1);

  slp_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_AWAKE: begin
        cnt_d = '0;
        if (req_s) state_d = ST_ENTER;
      end
      ST_ENTER: begin
        if (!req_s) begin
          state_d = ST_AWAKE;
          cnt_d   = '0;
        end else if (cnt_q == ENT_LAST) begin
          state_d = ST_ASLEEP;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_ASLEEP: begin
        cnt_d = '0;
        if (!req_s) state_d = ST_EXIT;
      end
      ST_EXIT: begin
        if (req_s) begin
          state_d = ST_ASLEEP;
          cnt_d   = '0;
        end else if (cnt_q == EXT_LAST) begin
          state_d = ST_RECOV;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_RECOV: begin
        if (cnt_q == REC_LAST) begin
          state_d = ST_AWAKE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        state_d = ST_AWAKE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_AWAKE;
      cnt_q   <= '0;
      sleep_q <= 1'b0;
      inhib_q <= 1'b0;
      recov_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sleep_q <= (state_d == ST_ASLEEP) || (state_d == ST_EXIT);
      inhib_q <= (state_d != ST_AWAKE);
      recov_q <= (state_d == ST_RECOV);
    end
  end

  assign enter_evt = (state_q == ST_AWAKE) && req_s;

  // R2: rest is only reached through the entry phase
  p_sleep_via_enter_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(sleep_q) |-> $past(state_q == ST_ENTER));

  // R4: blocking covers the whole rest state
  p_inhibit_covers_sleep_r4: assert property (@(posedge clk) disable iff (rst)
    sleep_q |-> inhib_q);

  // R3: guard window only opens straight out of rest
  p_recov_after_sleep_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(recov_q) |-> $past(sleep_q));

  // R6: a lost request during entry returns to awake
  p_abort_entry_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ENTER && !req_s) |=> !sleep_q && !inhib_q);
endmodule

// File: rtl/slp_guard.sv
module slp_guard (
  input  logic clk,
  input  logic rst,
  input  logic enter_evt,
  input  logic in_recov,
  input  logic chip_sel,
  input  logic strb_proc,
  input  logic strb_ctrl,
  output logic viol_q
);
  logic any_act;
  assign any_act = chip_sel | strb_proc | strb_ctrl;

  always_ff @(posedge clk) begin
    if (rst) viol_q <= 1'b0;
    else if ((enter_evt && chip_sel) || (in_recov && any_act)) viol_q <= 1'b1;
  end

  // R9: the flag never clears outside reset
  p_viol_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    viol_q |=> viol_q);

  // R7: any activity in the guard window is caught
  p_viol_in_recov_r7: assert property (@(posedge clk) disable iff (rst)
    (in_recov && any_act) |=> viol_q);

  // R8: entry while selected is caught
  p_viol_on_entry_r8: assert property (@(posedge clk) disable iff (rst)
    (enter_evt && chip_sel) |=> viol_q);
endmodule

// File: rtl/slp_mode_ctrl.sv
module slp_mode_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int ENTRY_CYC   = 2,
  parameter int EXIT_CYC    = 2,
  parameter int RECOV_CYC   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sleep_req_async,
  input  logic chip_sel,
  input  logic strb_proc,
  input  logic strb_ctrl,
  input  logic core_wr,
  input  logic core_oe,
  output logic sleep_active,
  output logic access_inhibit,
  output logic recov_busy,
  output logic violation,
  output logic arr_wr_en,
  output logic dq_drive_en
);
  logic req_s;
  logic enter_evt;

  slp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (sleep_req_async),
    .dout (req_s)
  );

  slp_fsm #(
    .ENTRY_CYC (ENTRY_CYC),
    .EXIT_CYC  (EXIT_CYC),
    .RECOV_CYC (RECOV_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req_s     (req_s),
    .enter_evt (enter_evt),
    .sleep_q   (sleep_active),
    .inhib_q   (access_inhibit),
    .recov_q   (recov_busy)
  );

  slp_guard u_guard (
    .clk       (clk),
    .rst       (rst),
    .enter_evt (enter_evt),
    .in_recov  (recov_busy),
    .chip_sel  (chip_sel),
    .strb_proc (strb_proc),
    .strb_ctrl (strb_ctrl),
    .viol_q    (violation)
  );

  assign arr_wr_en   = core_wr & ~access_inhibit;
  assign dq_drive_en = core_oe & ~access_inhibit;

  // R4: the array is never written while at rest
  p_no_write_asleep_r4: assert property (@(posedge clk) disable iff (rst)
    sleep_active |-> !arr_wr_en && !dq_drive_en);

  // R3: guard window and rest never overlap
  p_recov_not_asleep_r3: assert property (@(posedge clk) disable iff (rst)
    recov_busy |-> !sleep_active);
endmodule

// File: tb/slp_mode_ctrl_bench.sv
module slp_mode_ctrl_bench;
  logic clk = 1'b0;
  logic rst, req, csel, sp, sc, cwr, coe;
  logic sleep_active, access_inhibit, recov_busy, violation, arr_wr_en, dq_drive_en;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  slp_mode_ctrl u_slp_mode_ctrl (
    .clk(clk), .rst(rst), .sleep_req_async(req), .chip_sel(csel),
    .strb_proc(sp), .strb_ctrl(sc), .core_wr(cwr), .core_oe(coe),
    .sleep_active(sleep_active), .access_inhibit(access_inhibit),
    .recov_busy(recov_busy), .violation(violation),
    .arr_wr_en(arr_wr_en), .dq_drive_en(dq_drive_en)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; req = 0; csel = 0; sp = 0; sc = 0; cwr = 0; coe = 0;
    tick(3);
    rst = 0;
  endtask

  // enter rest: request raised now, return after sleep_active rises
  task automatic go_sleep();
    req = 1;
    tick(4);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 sleep_active", sleep_active, 0);
    chk("R1 access_inhibit", access_inhibit, 0);
    chk("R1 recov_busy", recov_busy, 0);
    chk("R1 violation", violation, 0);
  endtask

  task automatic t_entry_exit();
    do_reset();
    cwr = 1; coe = 1;
    tick(1);
    chk("R5 arr_wr_en awake", arr_wr_en, 1);
    chk("R5 dq_drive_en awake", dq_drive_en, 1);
    req = 1;
    tick(2);
    chk("R2 inhibit after k+1", access_inhibit, 0);
    tick(1);
    chk("R2 inhibit after k+2", access_inhibit, 1);
    chk("R2 sleep after k+2", sleep_active, 0);
    chk("R4 arr_wr_en blocked", arr_wr_en, 0);
    chk("R4 dq_drive_en blocked", dq_drive_en, 0);
    tick(1);
    chk("R2 sleep after k+3", sleep_active, 1);
    tick(5);
    chk("R4 still blocked", arr_wr_en, 0);
    req = 0;
    tick(3);
    chk("R3 sleep after m+2", sleep_active, 1);
    tick(1);
    chk("R3 sleep after m+3", sleep_active, 0);
    chk("R3 recov after m+3", recov_busy, 1);
    chk("R4 inhibit in recov", access_inhibit, 1);
    chk("R4 write blocked in recov", arr_wr_en, 0);
    tick(1);
    chk("R3 recov after m+4", recov_busy, 1);
    tick(1);
    chk("R3 recov after m+5", recov_busy, 0);
    chk("R5 inhibit released", access_inhibit, 0);
    chk("R5 write passes again", arr_wr_en, 1);
    csel = 1; sp = 1; sc = 1;
    tick(2);
    chk("R10 no violation after window", violation, 0);
    csel = 0; sp = 0; sc = 0;
  endtask

  task automatic t_recov_violation();
    do_reset();
    go_sleep();
    req = 0;
    tick(4);
    chk("R7 recov open", recov_busy, 1);
    chk("R7 no flag yet", violation, 0);
    sc = 1;
    tick(1);
    chk("R7 flag after strobe", violation, 1);
    sc = 0;
    tick(10);
    chk("R9 flag held", violation, 1);
  endtask

  task automatic t_entry_selected();
    do_reset();
    csel = 1; req = 1;
    tick(2);
    chk("R8 no flag before entry", violation, 0);
    tick(1);
    chk("R8 flag at entry", violation, 1);
    chk("R8 inhibit at entry", access_inhibit, 1);
    tick(1);
    chk("R8 sleep still entered", sleep_active, 1);
    csel = 0;
  endtask

  task automatic t_abort();
    int saw_sleep = 0;
    do_reset();
    req = 1;
    tick(1);
    req = 0;
    tick(2);
    chk("R6 inhibit one cycle", access_inhibit, 1);
    tick(1);
    chk("R6 inhibit dropped", access_inhibit, 0);
    for (int i = 0; i < 6; i++) begin
      if (sleep_active) saw_sleep = 1;
      tick(1);
    end
    chk("R6 sleep never rose", saw_sleep, 0);
  endtask

  task automatic t_reassert();
    int low_seen = 0;
    int rec_seen = 0;
    do_reset();
    go_sleep();
    req = 0;
    tick(1);
    req = 1;
    for (int i = 0; i < 8; i++) begin
      tick(1);
      if (!sleep_active) low_seen = 1;
      if (recov_busy) rec_seen = 1;
    end
    chk("R11 stayed asleep", low_seen, 0);
    chk("R11 no recov", rec_seen, 0);
  endtask

  initial begin
    rst = 1; req = 0; csel = 0; sp = 0; sc = 0; cwr = 0; coe = 0;
    t_reset();
    t_entry_exit();
    t_recov_violation();
    t_entry_selected();
    t_abort();
    t_reassert();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule